// File: doc/BRIEF.md
# Register-Driven I2C Master Step Sequencer

This block is a byte-level I2C master controller that sits behind a small register bus. Software drives a transaction one step at a time: it requests a start condition, writes the address byte, then writes or reads data bytes, and finally requests a stop. The block keeps a 5-bit phase code in its status register that names the last completed step. It raises an interrupt flag when a step completes. The bit-level line timing belongs to a separate byte engine. This block talks to that engine through a command port with a valid/ready handshake. The commands are open-with-address, send byte, receive byte and close. The engine answers with an ack/nack bit and, for a receive, the byte it received.

Register accesses themselves advance the sequence. A data-register write sends either the address or a payload byte, depending on the phase. A data-register read fetches the next byte. A status read in the read-address phase moves the code on to the data-available phase, so that polling software sees the change. Rewriting the auto-ack bit swaps the two receive codes. When an access needs the engine, it completes only after the engine has answered. A parameter selects whether software clears the interrupt flag by writing it as 0 or by writing it as 1. A soft-reset register freezes the control and data paths while it is set. When it is released, it restores every register to its reset value.

Top module: `i2c_master_seq`

## Requirements
- R1: After reset these registers read back as follows: status (offset 0x10) reads 0xF8, line control (0x20) reads 0x3A, and offsets 0x00, 0x04, 0x08, 0x0C, 0x14, 0x18 and 0x1C read 0x00. A read of any unmapped offset returns 0x00.
- R2: A control write with start (bit 5) gives status code 1 if the phase is idle (0x1F) and code 2 otherwise. A control write with stop (bit 4) issues a close command (op 3) and returns the phase to idle. The start and stop bits always read back as 0. The status code sits in status bits 7:3.
- R3: A data write in phase 1 or 2 issues an open command (op 0) carrying the written byte, with bit 0 as the direction (1 = read). On ack the phase becomes 8 for a read or 3 for a write. On nack the phase becomes 4 and the interrupt flag is not set.
- R4: A data write in phase 3 or 5 issues a send command (op 1). On ack the phase becomes 5. On nack the phase becomes 6 and a close command (op 3) follows.
- R5: A data read in phase 8, 10 or 11 issues a receive command (op 2) and returns the received byte. The phase then becomes 10 if auto-ack (control bit 2) is set, or 11 if it is clear.
- R6: A status read in phase 8 returns 0x40 and then advances the phase to 10 or 11, following auto-ack.
- R7: A control write with auto-ack clear turns phase 10 into 11. A control write with auto-ack set turns phase 11 into 10.
- R8: The interrupt flag (control bit 3) is set when a step completes, but only if soft reset is clear, bus enable (bit 6) is set and the phase is not idle. The irq output is high only while both the flag and interrupt enable (bit 7) are set.
- R9: With W1C_CLEAR=0, a control write with bit 3 at 0 clears the flag and a write with bit 3 at 1 keeps it. With W1C_CLEAR=1, a write with bit 3 at 1 clears the flag and a write with bit 3 at 0 keeps it.
- R10: While soft reset (offset 0x18, bit 0) is 1, control and data writes are ignored. Writing it from 1 to 0 restores all registers to their reset values, and issues a close command if the phase was not idle.
- R11: The writable masks are 0x7F for clock control (0x14), 0x03 for the feature register (0x1C) and 0x3F for line control (0x20). Control bits 7, 6 and 2 are kept as written. The address register (0x00) takes all 8 bits. A data write is ignored while bus enable is clear.
- R12: Command fields stay stable while a command waits for ready. A register access that issues a command does not finish before the engine has answered. The access acknowledge is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_req | input | 1 | Register access request, held until reg_ack |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 8 | Write data |
| reg_ack | output | 1 | Access completion pulse |
| reg_rdata | output | 8 | Read data, valid with reg_ack |
| cmd_valid | output | 1 | Command to the byte engine is valid |
| cmd_ready | input | 1 | Byte engine accepts the command |
| cmd_op | output | 2 | 0 open, 1 send, 2 receive, 3 close |
| cmd_byte | output | 8 | Address byte or payload byte |
| rsp_valid | input | 1 | Engine response valid (not used for close) |
| rsp_nack | input | 1 | 1 = the byte was not acknowledged |
| rsp_data | input | 8 | Received byte |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted phase code becomes visible as soon as software reads status. It also shows up earlier, at the command port: the wrong command, or no command at all, follows the next data access. A flag error reaches the irq pin on the clock edge that ends the access, and the bench compares that pin with its model every cycle. If soft reset fails to freeze the block, the frozen control value changes, and the read straight after the ignored write shows it.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  localparam int REG_AW  = 6;
  localparam int BYTE_W  = 8;
  localparam int CODE_W  = 5;

  localparam logic [REG_AW-1:0] OFS_ADDR  = 6'h00;
  localparam logic [REG_AW-1:0] OFS_XADDR = 6'h04;
  localparam logic [REG_AW-1:0] OFS_DATA  = 6'h08;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 6'h0C;
  localparam logic [REG_AW-1:0] OFS_STAT  = 6'h10;
  localparam logic [REG_AW-1:0] OFS_CLK   = 6'h14;
  localparam logic [REG_AW-1:0] OFS_SRST  = 6'h18;
  localparam logic [REG_AW-1:0] OFS_FEAT  = 6'h1C;
  localparam logic [REG_AW-1:0] OFS_LINE  = 6'h20;

  typedef logic [CODE_W-1:0] code_t;

  localparam code_t C_START   = 5'd1;
  localparam code_t C_RESTART = 5'd2;
  localparam code_t C_AW_ACK  = 5'd3;
  localparam code_t C_AW_NACK = 5'd4;
  localparam code_t C_TX_ACK  = 5'd5;
  localparam code_t C_TX_NACK = 5'd6;
  localparam code_t C_AR_ACK  = 5'd8;
  localparam code_t C_RX_ACK  = 5'd10;
  localparam code_t C_RX_NACK = 5'd11;
  localparam code_t C_IDLE    = 5'h1F;

  // control bit positions (software decodes these)
  localparam int CB_IE   = 7;
  localparam int CB_BUS  = 6;
  localparam int CB_STA  = 5;
  localparam int CB_STP  = 4;
  localparam int CB_FLAG = 3;
  localparam int CB_AA   = 2;

  // bits kept as written; start/stop self-clear and the flag has its own rule
  localparam logic [BYTE_W-1:0] CTRL_KEEP = 8'hC4;
  localparam logic [BYTE_W-1:0] CLK_MASK  = 8'h7F;
  localparam logic [BYTE_W-1:0] FEAT_MASK = 8'h03;
  localparam logic [BYTE_W-1:0] LINE_MASK = 8'h3F;
  localparam logic [BYTE_W-1:0] LINE_INIT = 8'h3A;

  typedef enum logic [1:0] {OP_OPEN, OP_SEND, OP_RECV, OP_CLOSE} op_e;

  typedef struct packed {
    logic [BYTE_W-1:0] addr;
    logic [BYTE_W-1:0] xaddr;
    logic [BYTE_W-1:0] data;
    logic [BYTE_W-1:0] ctrl;
    logic [BYTE_W-1:0] clkdiv;
    logic [BYTE_W-1:0] feat;
    logic [BYTE_W-1:0] line;
    logic              srst;
    code_t             code;
  } regs_t;

  function automatic regs_t regs_reset();
    regs_t r;
    r = '0;
    r.line = LINE_INIT;
    r.code = C_IDLE;
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] stat_byte(code_t c);
    return {c, 3'b000};
  endfunction

  function automatic code_t rx_code(logic aa);
    return aa ? C_RX_ACK : C_RX_NACK;
  endfunction

  function automatic code_t addr_ack_code(logic dir_rd);
    return dir_rd ? C_AR_ACK : C_AW_ACK;
  endfunction

  function automatic logic is_rx_code(code_t c);
    return (c == C_AR_ACK) || (c == C_RX_ACK) || (c == C_RX_NACK);
  endfunction

  function automatic logic flag_keep(logic old, logic wbit, logic w1c);
    return w1c ? (old & ~wbit) : (old & wbit);
  endfunction

  // control value after a completed step
  function automatic logic [BYTE_W-1:0] raise_flag(regs_t r);
    logic [BYTE_W-1:0] c;
    c = r.ctrl;
    if (!r.srst && r.ctrl[CB_BUS] && (r.code != C_IDLE)) c[CB_FLAG] = 1'b1;
    return c;
  endfunction

endpackage

// File: rtl/i2cm_cmd_port.sv
module i2cm_cmd_port
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  op_e               go_op,
  input  logic [BYTE_W-1:0] go_byte,
  output logic              done,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [BYTE_W-1:0] cmd_byte,
  input  logic              rsp_valid
);

  typedef enum logic [1:0] {P_IDLE, P_ISSUE, P_WAIT} port_e;

  port_e             st_q;
  op_e               op_q;
  logic [BYTE_W-1:0] byte_q;

  assign done = ((st_q == P_ISSUE) && cmd_ready && (op_q == OP_CLOSE)) ||
                ((st_q == P_WAIT) && rsp_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= P_IDLE;
      op_q   <= OP_CLOSE;
      byte_q <= '0;
    end else if (go && (done || (st_q == P_IDLE))) begin
      st_q   <= P_ISSUE;
      op_q   <= go_op;
      byte_q <= go_byte;
    end else if (done) begin
      st_q <= P_IDLE;
    end else if ((st_q == P_ISSUE) && cmd_ready) begin
      st_q <= P_WAIT;
    end
  end

  assign cmd_valid = (st_q == P_ISSUE);
  assign cmd_op    = op_q;
  assign cmd_byte  = byte_q;

endmodule

// File: rtl/i2cm_read_mux.sv
module i2cm_read_mux
  import i2cm_pkg::*;
(
  input  regs_t             regs,
  input  logic [REG_AW-1:0] ofs,
  output logic [BYTE_W-1:0] value
);

  always_comb begin
    case (ofs)
      OFS_ADDR:  value = regs.addr;
      OFS_XADDR: value = regs.xaddr;
      OFS_DATA:  value = regs.data;
      OFS_CTRL:  value = regs.ctrl;
      OFS_STAT:  value = stat_byte(regs.code);
      OFS_CLK:   value = regs.clkdiv;
      OFS_SRST:  value = {7'b0, regs.srst};
      OFS_FEAT:  value = regs.feat;
      OFS_LINE:  value = regs.line;
      default:   value = '0;
    endcase
  end

endmodule

// File: rtl/i2c_master_seq.sv
module i2c_master_seq
  import i2cm_pkg::*;
#(
  parameter bit W1C_CLEAR = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_ack,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [BYTE_W-1:0] cmd_byte,
  input  logic              rsp_valid,
  input  logic              rsp_nack,
  input  logic [BYTE_W-1:0] rsp_data,
  output logic              irq
);

  typedef enum logic [1:0] {A_IDLE, A_CMD, A_CLOSE, A_ACK} acc_e;
  typedef enum logic [1:0] {K_ADDR, K_TX, K_RX} kind_e;

  regs_t             regs_q, regs_n;
  acc_e              acc_q, acc_n;
  kind_e             kind_q, kind_n;
  logic [BYTE_W-1:0] rdata_q, rdata_n;
  logic [BYTE_W-1:0] rd_value;
  logic              go, done;
  op_e               go_op;
  logic [BYTE_W-1:0] go_byte;

  // named internal events and state for the checker
  logic              flag_q, bus_en_q, srst_q, int_en_q, ctrl_wr_evt;
  code_t             code_q;
  logic [BYTE_W-1:0] ctrl_q;

  assign flag_q      = regs_q.ctrl[CB_FLAG];
  assign bus_en_q    = regs_q.ctrl[CB_BUS];
  assign int_en_q    = regs_q.ctrl[CB_IE];
  assign srst_q      = regs_q.srst;
  assign code_q      = regs_q.code;
  assign ctrl_q      = regs_q.ctrl;
  assign ctrl_wr_evt = (acc_q == A_IDLE) && reg_req && reg_we && (reg_addr == OFS_CTRL);

  i2cm_read_mux u_rmux (
    .regs  (regs_q),
    .ofs   (reg_addr),
    .value (rd_value)
  );

  i2cm_cmd_port u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .go_op     (go_op),
    .go_byte   (go_byte),
    .done      (done),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_byte  (cmd_byte),
    .rsp_valid (rsp_valid)
  );

  always_comb begin
    regs_n  = regs_q;
    acc_n   = acc_q;
    kind_n  = kind_q;
    rdata_n = rdata_q;
    go      = 1'b0;
    go_op   = OP_CLOSE;
    go_byte = regs_q.data;
    case (acc_q)
      A_IDLE: begin
        if (reg_req) begin
          rdata_n = reg_we ? '0 : rd_value;
          if (reg_we) begin
            case (reg_addr)
              OFS_ADDR:  regs_n.addr   = reg_wdata;
              OFS_XADDR: regs_n.xaddr  = reg_wdata;
              OFS_CLK:   regs_n.clkdiv = reg_wdata & CLK_MASK;
              OFS_FEAT:  regs_n.feat   = reg_wdata & FEAT_MASK;
              OFS_LINE:  regs_n.line   = reg_wdata & LINE_MASK;
              OFS_SRST: begin
                if (!reg_wdata[0] && regs_q.srst) begin
                  regs_n = regs_reset();
                  go     = (regs_q.code != C_IDLE);
                end
                regs_n.srst = reg_wdata[0];
              end
              OFS_DATA: begin
                if (!regs_q.srst && regs_q.ctrl[CB_BUS]) begin
                  regs_n.data = reg_wdata;
                  go_byte     = reg_wdata;
                  if ((regs_q.code == C_START) || (regs_q.code == C_RESTART)) begin
                    go     = 1'b1;
                    go_op  = OP_OPEN;
                    kind_n = K_ADDR;
                  end else if ((regs_q.code == C_AW_ACK) || (regs_q.code == C_TX_ACK)) begin
                    go     = 1'b1;
                    go_op  = OP_SEND;
                    kind_n = K_TX;
                  end
                end
              end
              OFS_CTRL: begin
                if (!regs_q.srst) begin
                  regs_n.ctrl          = reg_wdata & CTRL_KEEP;
                  regs_n.ctrl[CB_FLAG] = flag_keep(regs_q.ctrl[CB_FLAG],
                                                   reg_wdata[CB_FLAG], W1C_CLEAR);
                  if (reg_wdata[CB_STA])
                    regs_n.code = (regs_q.code == C_IDLE) ? C_START : C_RESTART;
                  if (reg_wdata[CB_STP]) begin
                    regs_n.code = C_IDLE;
                    go          = 1'b1;
                  end
                  if (!reg_wdata[CB_AA] && (regs_n.code == C_RX_ACK))
                    regs_n.code = C_RX_NACK;
                  else if (reg_wdata[CB_AA] && (regs_n.code == C_RX_NACK))
                    regs_n.code = C_RX_ACK;
                  if (reg_wdata[CB_STA] && !reg_wdata[CB_STP])
                    regs_n.ctrl = raise_flag(regs_n);
                end
              end
              default: ;
            endcase
          end else begin
            if ((reg_addr == OFS_DATA) && is_rx_code(regs_q.code)) begin
              go     = 1'b1;
              go_op  = OP_RECV;
              kind_n = K_RX;
            end else if ((reg_addr == OFS_STAT) && (regs_q.code == C_AR_ACK)) begin
              regs_n.code = rx_code(regs_q.ctrl[CB_AA]);
              regs_n.ctrl = raise_flag(regs_n);
            end
          end
          if (!go)                    acc_n = A_ACK;
          else if (go_op == OP_CLOSE) acc_n = A_CLOSE;
          else                        acc_n = A_CMD;
        end
      end
      A_CMD: begin
        if (done) begin
          acc_n = A_ACK;
          case (kind_q)
            K_ADDR: begin
              if (rsp_nack) regs_n.code = C_AW_NACK;
              else begin
                regs_n.code = addr_ack_code(regs_q.data[0]);
                regs_n.ctrl = raise_flag(regs_n);
              end
            end
            K_TX: begin
              if (rsp_nack) begin
                regs_n.code = C_TX_NACK;
                go          = 1'b1;
                acc_n       = A_CLOSE;
              end else begin
                regs_n.code = C_TX_ACK;
                regs_n.ctrl = raise_flag(regs_n);
              end
            end
            default: begin
              regs_n.data = rsp_data;
              regs_n.code = rx_code(regs_q.ctrl[CB_AA]);
              regs_n.ctrl = raise_flag(regs_n);
              rdata_n     = rsp_data;
            end
          endcase
        end
      end
      A_CLOSE: if (done) acc_n = A_ACK;
      default: acc_n = A_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q  <= regs_reset();
      acc_q   <= A_IDLE;
      kind_q  <= K_ADDR;
      rdata_q <= '0;
    end else begin
      regs_q  <= regs_n;
      acc_q   <= acc_n;
      kind_q  <= kind_n;
      rdata_q <= rdata_n;
    end
  end

  assign reg_ack   = (acc_q == A_ACK);
  assign reg_rdata = rdata_q;
  assign irq       = regs_q.ctrl[CB_IE] & regs_q.ctrl[CB_FLAG];

endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_ack,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic [7:0] cmd_byte,
  input logic       flag_q,
  input logic       bus_en_q,
  input logic       srst_q,
  input logic [4:0] code_q,
  input logic [7:0] ctrl_q,
  input logic       ctrl_wr_evt
);

  a_r12_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_byte));

  a_r12_no_ack_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !reg_ack);

  a_r12_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_ack |=> !reg_ack);

  a_r8_flag_rise_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> (code_q != 5'h1F) && bus_en_q && !srst_q);

  a_r3_addr_nack_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == 5'd4) && ($past(code_q) != 5'd4) |-> $stable(flag_q));

  a_r10_srst_freezes_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_evt && srst_q |=> $stable(ctrl_q) && $stable(code_q));

  a_r5_recv_in_rx_phase: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == 2'd2) |-> (code_q == 5'd8) || (code_q == 5'd10) || (code_q == 5'd11));

endmodule

bind i2c_master_seq i2cm_checker u_i2cm_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_ack     (reg_ack),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_op      (cmd_op),
  .cmd_byte    (cmd_byte),
  .flag_q      (flag_q),
  .bus_en_q    (bus_en_q),
  .srst_q      (srst_q),
  .code_q      (code_q),
  .ctrl_q      (ctrl_q),
  .ctrl_wr_evt (ctrl_wr_evt)
);

// File: tb/i2c_master_seq_bench.sv
`timescale 1ns/1ps
module i2c_master_seq_bench;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic       reg_req, reg_we, reg_ack;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       cmd_valid, cmd_ready;
  logic [1:0] cmd_op;
  logic [7:0] cmd_byte;
  logic       rsp_valid, rsp_nack;
  logic [7:0] rsp_data;
  logic       irq;

  logic       w_req, w_we, w_ack, w_cmd_valid, w_irq;
  logic [5:0] w_addr;
  logic [7:0] w_wdata, w_rdata, w_cmd_byte;
  logic [1:0] w_cmd_op;

  i2c_master_seq #(.W1C_CLEAR(1'b0)) u_i2c_master_seq (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack),
    .reg_rdata(reg_rdata), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_byte(cmd_byte), .rsp_valid(rsp_valid),
    .rsp_nack(rsp_nack), .rsp_data(rsp_data), .irq(irq));

  i2c_master_seq #(.W1C_CLEAR(1'b1)) u_i2c_master_seq_w1c (
    .clk(clk), .rst_n(rst_n), .reg_req(w_req), .reg_we(w_we),
    .reg_addr(w_addr), .reg_wdata(w_wdata), .reg_ack(w_ack),
    .reg_rdata(w_rdata), .cmd_valid(w_cmd_valid), .cmd_ready(1'b0),
    .cmd_op(w_cmd_op), .cmd_byte(w_cmd_byte), .rsp_valid(1'b0),
    .rsp_nack(1'b0), .rsp_data(8'h00), .irq(w_irq));

  int n_chk = 0, n_fail = 0;
  bit busy = 1'b1;
  bit done_run = 1'b0;

  // engine behaviour and command log
  bit resp_nack = 1'b0;
  int resp_data = 0;
  int cmd_cnt = 0, rsp_cnt = 0, close_cnt = 0, last_op = -1, last_byte = -1;
  int pend = 0;

  // behavioural reference model (W1C_CLEAR = 0 instance)
  int m_code, m_ctrl, m_data, m_srst;

  task automatic chk(int act, int exp, string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void m_reset();
    m_code = 31; m_ctrl = 0; m_data = 0; m_srst = 0;
  endfunction

  function automatic void m_raise();
    if (m_srst == 0 && (m_ctrl & 'h40) != 0 && m_code != 31) m_ctrl = m_ctrl | 'h08;
  endfunction

  function automatic void m_write(int a, int v);
    int fl;
    case (a)
      'h18: begin
        if ((v & 1) == 0 && m_srst == 1) m_reset();
        m_srst = v & 1;
      end
      'h08: if (m_srst == 0 && (m_ctrl & 'h40) != 0) begin
        m_data = v;
        if (m_code == 1 || m_code == 2) begin
          if (resp_nack) m_code = 4;
          else begin m_code = ((v & 1) != 0) ? 8 : 3; m_raise(); end
        end else if (m_code == 3 || m_code == 5) begin
          if (resp_nack) m_code = 6;
          else begin m_code = 5; m_raise(); end
        end
      end
      'h0C: if (m_srst == 0) begin
        fl = ((v & 8) != 0) ? (m_ctrl & 8) : 0;
        m_ctrl = (v & 'hC4) | fl;
        if ((v & 'h20) != 0) m_code = (m_code == 31) ? 1 : 2;
        if ((v & 'h10) != 0) m_code = 31;
        if ((v & 4) == 0 && m_code == 10) m_code = 11;
        else if ((v & 4) != 0 && m_code == 11) m_code = 10;
        if ((v & 'h20) != 0 && (v & 'h10) == 0) m_raise();
      end
      default: ;
    endcase
  endfunction

  function automatic void m_read(int a);
    if (a == 'h08 && (m_code == 8 || m_code == 10 || m_code == 11)) begin
      m_data = resp_data;
      m_code = ((m_ctrl & 4) != 0) ? 10 : 11;
      m_raise();
    end else if (a == 'h10 && m_code == 8) begin
      m_code = ((m_ctrl & 4) != 0) ? 10 : 11;
      m_raise();
    end
  endfunction

  // byte engine: accepts a command, answers two cycles later
  initial begin
    cmd_ready = 1'b0; rsp_valid = 1'b0; rsp_nack = 1'b0; rsp_data = 8'h00;
    forever begin
      @(negedge clk);
      cmd_ready = 1'b0; rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          rsp_valid = 1'b1; rsp_nack = resp_nack; rsp_data = 8'(resp_data); rsp_cnt++;
        end
      end else if (cmd_valid && rst_n) begin
        cmd_ready = 1'b1; cmd_cnt++;
        last_op = int'(cmd_op); last_byte = int'(cmd_byte);
        if (cmd_op == 2'd3) close_cnt++;
        else pend = 2;
      end
    end
  end

  // irq compared with the model on every clock outside accesses
  always @(negedge clk) begin
    if (!busy && rst_n && !done_run)
      chk(int'(irq), ((m_ctrl >> 7) & (m_ctrl >> 3) & 1), "R8 irq vs model");
  end

  task automatic acc(bit we, int a, int v, output int rd);
    @(negedge clk);
    busy = 1'b1;
    reg_req = 1'b1; reg_we = we; reg_addr = 6'(a); reg_wdata = 8'(v);
    do @(negedge clk); while (!reg_ack);
    rd = int'(reg_rdata);
    reg_req = 1'b0; reg_we = 1'b0;
  endtask

  task automatic wr(int a, int v);
    int d;
    acc(1'b1, a, v, d);
    m_write(a, v);
    busy = 1'b0;
  endtask

  task automatic rd(int a, int exp, string tag);
    int d;
    acc(1'b0, a, 0, d);
    m_read(a);
    busy = 1'b0;
    chk(d, exp, tag);
  endtask

  task automatic wacc(bit we, int a, int v, output int r);
    @(negedge clk);
    w_req = 1'b1; w_we = we; w_addr = 6'(a); w_wdata = 8'(v);
    do @(negedge clk); while (!w_ack);
    r = int'(w_rdata);
    w_req = 1'b0; w_we = 1'b0;
  endtask

  function automatic void summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    int r, snap;
    rst_n = 1'b0; reg_req = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    w_req = 1'b0; w_we = 1'b0; w_addr = '0; w_wdata = '0;
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    busy = 1'b0;

    // R1 reset values and unmapped offset
    rd('h00, 'h00, "R1 addr"); rd('h04, 'h00, "R1 xaddr"); rd('h08, 'h00, "R1 data");
    rd('h0C, 'h00, "R1 ctrl"); rd('h10, 'hF8, "R1 status"); rd('h14, 'h00, "R1 clk");
    rd('h18, 'h00, "R1 srst"); rd('h1C, 'h00, "R1 feat"); rd('h20, 'h3A, "R1 line");
    rd('h24, 'h00, "R1 unmapped");

    // R11 masks and bus-enable gate
    wr('h14, 'hFF); rd('h14, 'h7F, "R11 clk mask");
    wr('h1C, 'hFF); rd('h1C, 'h03, "R11 feat mask");
    wr('h20, 'hFF); rd('h20, 'h3F, "R11 line mask");
    wr('h00, 'h5A); rd('h00, 'h5A, "R11 addr reg");
    wr('h08, 'h55); rd('h08, 'h00, "R11 data ignored bus off");
    chk(cmd_cnt, 0, "R11 no command bus off");
    wr('h0C, 'hC4); rd('h0C, 'hC4, "R11 ctrl kept bits");

    // R2 start from idle, R8 flag
    wr('h0C, 'hE4); rd('h10, 'h08, "R2 start code");
    rd('h0C, 'hCC, "R2 start self-clear R8 flag");
    chk(int'(irq), 1, "R8 irq with enable");
    wr('h0C, 'hC4); rd('h0C, 'hC4, "R9 write-0 clears");
    chk(int'(irq), 0, "R9 irq low after clear");

    // R3 address write ack, R4 data
    resp_nack = 1'b0;
    wr('h08, 'hA0);
    chk(last_op, 0, "R3 open op"); chk(last_byte, 'hA0, "R3 open byte");
    chk(rsp_cnt, 1, "R12 access waited for response");
    rd('h10, 'h18, "R3 addr write ack code");
    wr('h08, 'h11); chk(last_op, 1, "R4 send op"); chk(last_byte, 'h11, "R4 send byte");
    rd('h10, 'h28, "R4 tx ack code");
    resp_nack = 1'b1;
    wr('h08, 'h22); rd('h10, 'h30, "R4 tx nack code");
    chk(last_op, 3, "R4 close after nack"); chk(close_cnt, 1, "R4 close count");
    resp_nack = 1'b0;

    // R2 repeated start, R6 status poll, R5 receive
    wr('h0C, 'hE4); rd('h10, 'h10, "R2 restart code");
    wr('h0C, 'hC4);
    wr('h08, 'hA1); rd('h10, 'h40, "R6 addr read ack code");
    rd('h10, 'h50, "R6 poll advanced to rx ack");
    resp_data = 'h3C;
    rd('h08, 'h3C, "R5 received byte"); chk(last_op, 2, "R5 recv op");
    rd('h10, 'h50, "R5 rx ack code");
    wr('h0C, 'hC0); rd('h10, 'h58, "R7 ack clear swaps");
    wr('h0C, 'hC4); rd('h10, 'h50, "R7 ack set swaps back");
    wr('h0C, 'hC0); resp_data = 'h7E;
    rd('h08, 'h7E, "R5 second byte"); rd('h10, 'h58, "R5 rx nack code");

    // R2 stop
    wr('h0C, 'hD0); rd('h10, 'hF8, "R2 stop idle");
    chk(last_op, 3, "R2 stop close op"); rd('h0C, 'hC0, "R2 stop self-clear");

    // R3 address nack
    wr('h0C, 'hE4); wr('h0C, 'hC4);
    resp_nack = 1'b1;
    wr('h08, 'hA2); rd('h10, 'h20, "R3 addr nack code");
    rd('h0C, 'hC4, "R3 no flag on nack");
    resp_nack = 1'b0;
    wr('h0C, 'hD4);

    // R8 gates: bus disabled, then interrupt disabled
    wr('h0C, 'h24); rd('h0C, 'h04, "R8 no flag bus off"); rd('h10, 'h08, "R8 code bus off");
    wr('h0C, 'h14);
    wr('h0C, 'h64); rd('h0C, 'h4C, "R8 flag without enable");
    chk(int'(irq), 0, "R8 irq needs enable");
    wr('h0C, 'h54);

    // R10 soft reset
    wr('h0C, 'hE4); wr('h14, 'h12); wr('h18, 'h01);
    rd('h18, 'h01, "R10 srst set");
    wr('h0C, 'hD0); rd('h10, 'h08, "R10 ctrl write ignored code");
    rd('h0C, 'hCC, "R10 ctrl write ignored value");
    snap = cmd_cnt;
    wr('h08, 'hA0); chk(cmd_cnt, snap, "R10 data write no command");
    rd('h08, 'hA2, "R10 data unchanged");
    snap = close_cnt;
    wr('h18, 'h00); chk(close_cnt, snap + 1, "R10 release closes transfer");
    rd('h14, 'h00, "R10 clk restored"); rd('h10, 'hF8, "R10 status restored");
    rd('h0C, 'h00, "R10 ctrl restored"); rd('h20, 'h3A, "R10 line restored");
    rd('h00, 'h00, "R10 addr restored");

    // R9 write-1 clear variant
    wacc(1'b1, 'h0C, 'h64, r); wacc(1'b0, 'h0C, 0, r); chk(r, 'h4C, "R9 w1c flag set");
    wacc(1'b1, 'h0C, 'h44, r); wacc(1'b0, 'h0C, 0, r); chk(r, 'h4C, "R9 w1c write 0 keeps");
    wacc(1'b1, 'h0C, 'h4C, r); wacc(1'b0, 'h0C, 0, r); chk(r, 'h44, "R9 w1c write 1 clears");

    done_run = 1'b1;
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule